// File: doc/BRIEF.md
# Two-Bucket Rate Conformance Shaper

This block polices one transmit queue against two token buckets, a committed bucket and a peak bucket. Each bucket is programmed with one 64-bit word. The word carries an enable, a rate and a burst size, and both the rate and the burst are coded as an 8-bit mantissa with an exponent. A per-bucket time wheel adds a fixed amount of credit once every `TICKS << divider` clock cycles. Each bucket's fill stays at or below its burst capacity.

When a packet is offered together with its byte length, the block compares the length with both bucket levels. One cycle later it returns a colour: green, yellow or red. In the same clock edge it takes the packet's bytes out of the buckets that the colour charges. A scheduler upstream uses the colour to send the packet, demote it or hold it back.

Credit is kept in units of 1/256 byte. A fractional amount added at one wheel event therefore carries over to the next event without loss.

Top module: `dual_bucket_shaper`

## Requirements
- R1: A write with `cfg_sel`=0 programs the committed bucket and a write with `cfg_sel`=1 programs the peak bucket. The word fields are: bit 0 enable, bits 8:1 rate mantissa, bits 12:9 rate exponent, bits 16:13 divider exponent, bits 36:29 burst mantissa and bits 40:37 burst exponent.
- R2: After reset both buckets are disabled and `col_valid` is 0.
- R3: A bucket whose enable bit is 0 never limits a packet, whatever the packet's length.
- R4: A packet offered on a clock edge gets `col_valid`=1 and a colour on the next cycle. The codes are green=0, yellow=1 and red=2. The colour is green when both buckets hold at least the length, yellow when only the peak bucket does, and red otherwise.
- R5: A green packet debits both buckets and a yellow packet debits only the peak bucket. A red packet debits neither bucket.
- R6: Each wheel event adds ((256+rate_mantissa) << rate_exponent)/256 bytes of credit. Fractions of a byte are kept between events.
- R7: A bucket's wheel fires once every (TICKS << divider) cycles. A divider field above 12 acts as 12.
- R8: A bucket's level never exceeds ((256+burst_mantissa) << (burst_exponent+1))/256 bytes.
- R9: Writing a configuration word fills that bucket to its burst capacity and restarts its wheel.
- R10: With 1-byte packets offered every cycle, the green byte count over a long window matches the start capacity plus the rate formula. The allowed error is one wheel event's credit plus one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Bucket select: 0 committed, 1 peak |
| cfg_data | input | 64 | Configuration word |
| pkt_valid | input | 1 | Packet offered this cycle |
| pkt_len | input | LEN_W (16) | Packet length in bytes |
| col_valid | output | 1 | Colour result valid |
| col | output | 2 | Colour: 0 green, 1 yellow, 2 red |

## Verification
The case that is hardest to reach from the ports is a divider field above 12. With the clamp in place the wheel period is tens of thousands of cycles, and only the bucket's refill shows the period. To reach it, the bench drains a bucket whose capacity equals one event's credit. It then offers a full-sized packet ten cycles before the clamped period expires, which must come back short of credit, and again ten cycles after, which must pass. The rate itself is checked by keeping 1-byte packets offered every cycle across thousands of cycles and counting the green results.

// File: rtl/shaper_pkg.sv
package shaper_pkg;
  localparam int FRAC_W      = 8;   // credit kept in 1/256 byte
  localparam int MAN_W       = 8;
  localparam int EXP_W       = 4;
  localparam int MAX_DIV_EXP = 12;
  // largest burst capacity is 511 << 16, plus headroom for one credit add
  localparam int LVL_W       = MAN_W + 1 + (1 << EXP_W) + 1;

  typedef enum logic [1:0] {
    COL_GREEN  = 2'd0,
    COL_YELLOW = 2'd1,
    COL_RED    = 2'd2
  } colour_e;

  typedef struct packed {
    logic [EXP_W-1:0] burst_exp;
    logic [MAN_W-1:0] burst_man;
    logic [EXP_W-1:0] div_exp;
    logic [EXP_W-1:0] rate_exp;
    logic [MAN_W-1:0] rate_man;
    logic             en;
  } bucket_cfg_t;

  function automatic bucket_cfg_t unpack_cfg(input logic [63:0] w);
    bucket_cfg_t c;
    c.en        = w[0];
    c.rate_man  = w[8:1];
    c.rate_exp  = w[12:9];
    c.div_exp   = w[16:13];
    c.burst_man = w[36:29];
    c.burst_exp = w[40:37];
    return c;
  endfunction

  function automatic logic [LVL_W-1:0] burst_cap(input bucket_cfg_t c);
    return LVL_W'({1'b1, c.burst_man}) << ({1'b0, c.burst_exp} + 5'd1);
  endfunction

  function automatic logic [LVL_W-1:0] rate_credit(input bucket_cfg_t c);
    return LVL_W'({1'b1, c.rate_man}) << c.rate_exp;
  endfunction
endpackage

// File: rtl/shaper_wheel.sv
module shaper_wheel #(
  parameter int TICKS   = 860,
  parameter int MAX_DIV = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       en,
  input  logic [3:0] div_exp,
  output logic       tick
);
  localparam int CNT_W = $clog2(TICKS) + MAX_DIV + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic [3:0]       div_eff;
  logic             cnt_en;

  always_comb begin
    div_eff = (div_exp > 4'(MAX_DIV)) ? 4'(MAX_DIV) : div_exp;
    limit   = (CNT_W'(TICKS) << div_eff) - CNT_W'(1);
    tick    = en && !restart && (cnt_q == limit);
    cnt_en  = restart || en;
    if (restart || cnt_q == limit) cnt_d = '0;
    else                           cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/shaper_bucket.sv
module shaper_bucket
  import shaper_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [63:0]      cfg_word,
  input  logic             tick,
  input  logic             take,
  input  logic [LEN_W-1:0] len,
  output bucket_cfg_t      cfg_q,
  output logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] cap,
  output logic             fits
);
  localparam int NEED_W = LEN_W + FRAC_W;
  localparam int CMP_W  = (LVL_W > NEED_W) ? LVL_W : NEED_W;

  bucket_cfg_t      cfg_new;
  logic [CMP_W-1:0] need;
  logic [LVL_W-1:0] drained, lvl_d;
  logic [LVL_W:0]   grown;
  logic             take_eff, lvl_en;

  always_comb begin
    cfg_new  = unpack_cfg(cfg_word);
    cap      = burst_cap(cfg_q);
    need     = CMP_W'(len) << FRAC_W;
    fits     = !cfg_q.en || (CMP_W'(level) >= need);
    take_eff = take && cfg_q.en && fits;
    drained  = level - (take_eff ? need[LVL_W-1:0] : '0);
    grown    = {1'b0, drained} + (tick ? {1'b0, rate_credit(cfg_q)} : '0);
    if (load)                      lvl_d = burst_cap(cfg_new);
    else if (grown > {1'b0, cap})  lvl_d = cap;
    else                           lvl_d = grown[LVL_W-1:0];
    lvl_en   = load || take_eff || tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (load) cfg_q <= cfg_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      level <= '0;
    else if (lvl_en) level <= lvl_d;
  end
endmodule

// File: rtl/dual_bucket_shaper.sv
module dual_bucket_shaper
  import shaper_pkg::*;
#(
  parameter int TICKS = 860,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [63:0]      cfg_data,
  input  logic             pkt_valid,
  input  logic [LEN_W-1:0] pkt_len,
  output logic             col_valid,
  output logic [1:0]       col
);
  localparam int NB = 2;  // index 0 committed, 1 peak

  logic [NB-1:0]            fits_w, tick_w, take_w, load_w;
  logic [NB-1:0][LVL_W-1:0] lvl_w, cap_w;
  logic [NB-1:0]            en_w;
  colour_e                  col_d;
  logic                     unused_bits;

  assign unused_bits = ^{cfg_data[63:41], cfg_data[28:17]};

  for (genvar b = 0; b < NB; b++) begin : g_bucket
    bucket_cfg_t cfg_b;
    assign load_w[b] = cfg_we && (cfg_sel == 1'(b));
    assign en_w[b]   = cfg_b.en;

    shaper_wheel #(.TICKS(TICKS), .MAX_DIV(MAX_DIV_EXP)) u_wheel (
      .clk(clk), .rst_n(rst_n), .restart(load_w[b]), .en(cfg_b.en),
      .div_exp(cfg_b.div_exp), .tick(tick_w[b])
    );

    shaper_bucket #(.LEN_W(LEN_W)) u_bucket (
      .clk(clk), .rst_n(rst_n), .load(load_w[b]), .cfg_word(cfg_data),
      .tick(tick_w[b]), .take(take_w[b]), .len(pkt_len),
      .cfg_q(cfg_b), .level(lvl_w[b]), .cap(cap_w[b]), .fits(fits_w[b])
    );
  end

  always_comb begin
    if (fits_w[0] && fits_w[1]) col_d = COL_GREEN;
    else if (fits_w[1])         col_d = COL_YELLOW;
    else                        col_d = COL_RED;
    take_w[0] = pkt_valid && (col_d == COL_GREEN);
    take_w[1] = pkt_valid && (col_d != COL_RED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_valid <= 1'b0;
    else        col_valid <= pkt_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         col <= 2'd0;
    else if (pkt_valid) col <= col_d;
  end
endmodule

// File: rtl/shaper_checker.sv
module shaper_checker
  import shaper_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_we,
  input logic                 cfg_sel,
  input logic                 pkt_valid,
  input logic                 col_valid,
  input logic [1:0]           col,
  input logic [1:0][LVL_W-1:0] lvl,
  input logic [1:0][LVL_W-1:0] cap
);
  assert_col_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> col_valid);

  assert_col_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> !col_valid);

  assert_col_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> col != 2'd3);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl[0] <= cap[0]) && (lvl[1] <= cap[1]));

  assert_refill_cir_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel) |=> lvl[0] == cap[0]);

  assert_refill_pir_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel) |=> lvl[1] == cap[1]);

  assert_red_no_debit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col == 2'd2 && !$past(cfg_we))
      |-> (lvl[0] >= $past(lvl[0])) && (lvl[1] >= $past(lvl[1])));
endmodule

bind dual_bucket_shaper shaper_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .pkt_valid(pkt_valid), .col_valid(col_valid), .col(col),
  .lvl(lvl_w), .cap(cap_w)
);

// File: tb/sim_dual_bucket_shaper.sv
module sim_dual_bucket_shaper;
  localparam int TICKS = 20;
  localparam int LEN_W = 16;
  localparam int WIN   = 4000;
  localparam int NVEC  = 3;
  // {rate_man, rate_exp, div_exp, burst_man, burst_exp}
  localparam logic [27:0] VECS [NVEC] = '{
    {8'd128, 4'd2, 4'd1, 8'd0,   4'd2},
    {8'd64,  4'd0, 4'd0, 8'd0,   4'd1},
    {8'd0,   4'd3, 4'd2, 8'd128, 4'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [63:0] cfg_data = '0;
  logic pkt_valid = 1'b0;
  logic [LEN_W-1:0] pkt_len = '0;
  logic col_valid;
  logic [1:0] col;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dual_bucket_shaper #(.TICKS(TICKS), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
    .col_valid(col_valid), .col(col)
  );

  function automatic logic [63:0] mk(input logic en, input int m, input int e,
                                     input int d, input int bm, input int be);
    return 64'(en) | (64'(m) << 1) | (64'(e) << 9) | (64'(d) << 13) |
           (64'(bm) << 29) | (64'(be) << 37);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic sel, input logic [63:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_data = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic offer(input int len, input int exp_col, input string req);
    @(negedge clk); pkt_valid = 1'b1; pkt_len = LEN_W'(len);
    @(negedge clk); pkt_valid = 1'b0;
    check(req, {col_valid, col}, {1'b1, 2'(exp_col)});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 col_valid after reset", col_valid, 0);
    offer(65535, 0, "R2 R3 both disabled, huge packet green");

    // committed bucket only: cap 8 bytes, wheel too slow to matter
    write_cfg(1'b0, mk(1, 0, 0, 12, 0, 2));
    offer(9, 1, "R3 R4 peak disabled, committed short -> yellow");
    offer(8, 0, "R5 yellow left committed intact, equal length green");
    offer(1, 1, "R5 green drained committed");

    // peak cap 16, committed refilled to 8
    write_cfg(1'b1, mk(1, 0, 0, 12, 0, 3));
    write_cfg(1'b0, mk(1, 0, 0, 12, 0, 2));
    offer(20, 2, "R4 longer than both -> red");
    offer(8, 0, "R5 red debited neither");
    offer(8, 1, "R5 committed empty, peak has 8 -> yellow");
    offer(1, 2, "R5 yellow debited peak -> red");

    write_cfg(1'b0, mk(1, 0, 0, 12, 0, 2));
    write_cfg(1'b1, mk(1, 0, 0, 12, 0, 3));
    offer(8, 0, "R9 R1 rewrite refills both buckets");

    // saturation: credit 6 B every 20 cycles, cap 8 B
    write_cfg(1'b1, 64'd0);
    write_cfg(1'b0, mk(1, 128, 2, 0, 0, 2));
    repeat (300) @(negedge clk);
    offer(9, 1, "R8 level held at cap");
    offer(8, 0, "R8 cap reached");

    // throughput vectors
    for (int v = 0; v < NVEC; v++) begin
      int m, e, d, bm, be, period, green, cred256, cap256, events, expb, tol, diff;
      {m, e, d, bm, be} = {24'd0, VECS[v][27:20], 28'd0, VECS[v][19:16],
                           28'd0, VECS[v][15:12], 24'd0, VECS[v][11:4],
                           28'd0, VECS[v][3:0]};
      period  = TICKS << d;
      cred256 = (256 + m) << e;
      cap256  = (256 + bm) << (be + 1);
      events  = (WIN - 1) / period;
      expb    = (cap256 + cred256 * events) / 256;
      tol     = (cred256 + 255) / 256 + 1;
      write_cfg(1'b0, mk(1, m, e, d, bm, be));
      pkt_valid = 1'b1; pkt_len = 1;
      green = 0;
      for (int c = 0; c < WIN; c++) begin
        @(negedge clk);
        if (col_valid && col == 2'd0) green++;
      end
      pkt_valid = 1'b0;
      diff = green - expb;
      if (diff < 0) diff = -diff;
      checks++;
      if (diff > tol) begin
        fails++;
        $display("FAIL R10 R6 R7 vector %0d: actual %0d expected %0d", v, green, expb);
      end
    end

    // divider above 12 clamps to 12: period 20 << 12
    begin
      int p;
      p = TICKS << 12;
      write_cfg(1'b0, mk(1, 0, 3, 15, 0, 2));
      pkt_valid = 1'b1; pkt_len = 8;
      @(negedge clk); pkt_valid = 1'b0;
      check("R7 clamp: full bucket green", {col_valid, col}, 3'b100);
      repeat (p - 12) @(negedge clk);
      pkt_valid = 1'b1;
      @(negedge clk); pkt_valid = 1'b0;
      check("R7 clamp: no credit before period", {col_valid, col}, 3'b101);
      repeat (18) @(negedge clk);
      pkt_valid = 1'b1;
      @(negedge clk); pkt_valid = 1'b0;
      check("R7 clamp: credit after period", {col_valid, col}, 3'b100);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule